// File: doc/BRIEF.md
# USB Host Frame-Time Transfer Scheduler

This block decides, for each 1 ms USB frame, which transfer list the host controller may work on. A 14-bit frame-remaining counter is reloaded from a frame-interval input on every start-of-frame pulse. It then counts down by one on each bit-time tick and stops at zero.

Two programmable thresholds are compared against this counter. The periodic-start value marks the point in the frame after which periodic (interrupt and isochronous) work goes ahead of control/bulk work. The switch never cuts off a control/bulk transaction that has already been granted. The low-speed threshold sets the latest point at which a low-speed transaction may still begin.

A small configuration port writes and reads both thresholds. List traversal, descriptor fetch, packet serialisation and SOF token generation all sit outside the block. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `usb_frame_sched`

## Requirements
- R1: The periodic-start register is selected by cfg_addr=0. It holds 14 bits, resets to 0 and reads back with bits 15..14 as zero.
- R2: The low-speed threshold register is selected by cfg_addr=1. It holds 12 bits, resets to 0x628 and reads back with bits 15..12 as zero.
- R3: In the cycle after sof, frame_remaining equals frame_interval. After that it falls by one on each cycle with bit_tick high, and it stays at 0 once it reaches 0. If sof and bit_tick are high in the same cycle, sof wins.
- R4: periodic_prio rises one cycle after frame_remaining is less than or equal to a nonzero periodic-start value. It then stays high until the next sof.
- R5: A periodic-start value of 0 keeps periodic_prio low for the whole frame, so control/bulk keeps priority.
- R6: From idle, a grant rises one cycle after the requests are seen. While periodic_prio is high, a pending per_req wins. While it is low, a pending cb_req wins. If only one list is requesting, that list is granted.
- R7: At most one of per_grant and cb_grant is high at any time. A grant stays high for as long as its busy input is high. It falls one cycle after busy is seen low, so a control/bulk transaction in flight is never cut off when periodic priority arrives.
- R8: ls_permit rises one cycle after ls_req only if frame_remaining is strictly greater than the low-speed threshold.
- R9: An ls_req refused for lack of time sets ls_deferred. While ls_deferred is high, ls_permit stays low. The next sof clears ls_deferred, and a request still held is then granted in the cycle that follows.
- R10: sof clears periodic_prio, so control/bulk requests win again at the start of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the threshold registers |
| cfg_addr | input | 1 | 0 = periodic start, 1 = low-speed threshold |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| sof | input | 1 | Start-of-frame pulse |
| frame_interval | input | 14 | Reload value for the frame counter |
| bit_tick | input | 1 | One pulse per bit time |
| frame_remaining | output | 14 | Bit times left in the current frame |
| per_req | input | 1 | Periodic list has work |
| per_busy | input | 1 | Periodic transaction in progress |
| per_grant | output | 1 | Periodic list may be serviced |
| cb_req | input | 1 | Control/bulk list has work |
| cb_busy | input | 1 | Control/bulk transaction in progress |
| cb_grant | output | 1 | Control/bulk list may be serviced |
| periodic_prio | output | 1 | Periodic priority is in force for this frame |
| ls_req | input | 1 | A low-speed transaction wants to start |
| ls_permit | output | 1 | Low-speed start allowed |
| ls_deferred | output | 1 | Low-speed request refused until next frame |

## Verification
A counter that is off by one moves every threshold crossing by one bit time. This shows up within a single frame as a wrong frame_remaining value, as periodic_prio rising one cycle early or late, or as ls_permit flipping at the exact threshold. A stuck or early-set priority flag shows up in the next arbitration cycle as the wrong grant. A grant state that drops while busy is high shows up one cycle later as a lost cb_grant, or as a per_grant appearing while control/bulk is still busy. A deferred bit that is never cleared shows up one cycle after the next sof, when a held low-speed request gets no permit.

// File: rtl/usb_fs_pkg.sv
`timescale 1ns/1ps
package usb_fs_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_CB   = 2'd1,
    ARB_PER  = 2'd2
  } arb_state_e;

  localparam logic CFG_SEL_PSTART = 1'b0;
  localparam logic CFG_SEL_LSTHR  = 1'b1;
endpackage

// File: rtl/usb_fs_cfg_regs.sv
`timescale 1ns/1ps
module usb_fs_cfg_regs #(
  parameter int DATA_W = 16,
  parameter int PS_W   = 14,
  parameter int LST_W  = 12,
  parameter logic [LST_W-1:0] LST_RST = 12'h628
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PS_W-1:0]   ps_q,
  output logic [LST_W-1:0]  lst_q
);
  import usb_fs_pkg::*;

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:PS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q  <= '0;
      lst_q <= LST_RST;
    end else if (wr_en) begin
      if (addr == CFG_SEL_PSTART) ps_q  <= wdata[PS_W-1:0];
      else                        lst_q <= wdata[LST_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CFG_SEL_LSTHR) rdata[LST_W-1:0] = lst_q;
    else                       rdata[PS_W-1:0]  = ps_q;
  end
endmodule

// File: rtl/usb_fs_frame_timer.sv
`timescale 1ns/1ps
module usb_fs_frame_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  input  logic [CNT_W-1:0] pstart,
  output logic [CNT_W-1:0] remaining,
  output logic             prio
);
  logic at_zero;
  logic crossed;

  assign at_zero = (remaining == '0);
  assign crossed = (pstart != '0) && (remaining <= pstart);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (sof) begin
      remaining <= reload;
    end else if (tick && !at_zero) begin
      remaining <= remaining - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       prio <= 1'b0;
    else if (sof)     prio <= 1'b0;
    else if (crossed) prio <= 1'b1;
  end
endmodule

// File: rtl/usb_fs_arbiter.sv
`timescale 1ns/1ps
module usb_fs_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic prio,
  input  logic per_req,
  input  logic per_busy,
  input  logic cb_req,
  input  logic cb_busy,
  output logic per_grant,
  output logic cb_grant
);
  import usb_fs_pkg::*;

  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (prio) begin
          if (per_req)     state_d = ARB_PER;
          else if (cb_req) state_d = ARB_CB;
        end else begin
          if (cb_req)       state_d = ARB_CB;
          else if (per_req) state_d = ARB_PER;
        end
      end
      ARB_CB:  if (!cb_busy)  state_d = ARB_IDLE;
      ARB_PER: if (!per_busy) state_d = ARB_IDLE;
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign per_grant = (state_q == ARB_PER);
  assign cb_grant  = (state_q == ARB_CB);
endmodule

// File: rtl/usb_fs_ls_gate.sv
`timescale 1ns/1ps
module usb_fs_ls_gate #(
  parameter int REM_W = 14,
  parameter int LST_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             ls_req,
  input  logic [REM_W-1:0] remaining,
  input  logic [LST_W-1:0] threshold,
  output logic             permit,
  output logic             deferred
);
  logic enough_time;
  assign enough_time = remaining > REM_W'(threshold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      permit   <= 1'b0;
      deferred <= 1'b0;
    end else if (sof) begin
      permit   <= 1'b0;
      deferred <= 1'b0;
    end else begin
      permit   <= ls_req && !deferred && enough_time;
      deferred <= deferred || (ls_req && !enough_time);
    end
  end
endmodule

// File: rtl/usb_frame_sched.sv
`timescale 1ns/1ps
module usb_frame_sched #(
  parameter int DATA_W = 16,
  parameter int REM_W  = 14,
  parameter int LST_W  = 12,
  parameter logic [LST_W-1:0] LST_RST = 12'h628
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              sof,
  input  logic [REM_W-1:0]  frame_interval,
  input  logic              bit_tick,
  output logic [REM_W-1:0]  frame_remaining,
  input  logic              per_req,
  input  logic              per_busy,
  output logic              per_grant,
  input  logic              cb_req,
  input  logic              cb_busy,
  output logic              cb_grant,
  output logic              periodic_prio,
  input  logic              ls_req,
  output logic              ls_permit,
  output logic              ls_deferred
);
  logic [REM_W-1:0] ps_val;
  logic [LST_W-1:0] lst_val;

  usb_fs_cfg_regs #(
    .DATA_W(DATA_W), .PS_W(REM_W), .LST_W(LST_W), .LST_RST(LST_RST)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ps_q(ps_val), .lst_q(lst_val)
  );

  usb_fs_frame_timer #(.CNT_W(REM_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .reload(frame_interval),
    .tick(bit_tick), .pstart(ps_val), .remaining(frame_remaining),
    .prio(periodic_prio)
  );

  usb_fs_arbiter arb_i (
    .clk(clk), .rst_n(rst_n), .prio(periodic_prio),
    .per_req(per_req), .per_busy(per_busy),
    .cb_req(cb_req), .cb_busy(cb_busy),
    .per_grant(per_grant), .cb_grant(cb_grant)
  );

  usb_fs_ls_gate #(.REM_W(REM_W), .LST_W(LST_W)) ls_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .ls_req(ls_req),
    .remaining(frame_remaining), .threshold(lst_val),
    .permit(ls_permit), .deferred(ls_deferred)
  );
endmodule

// File: rtl/usb_frame_sched_chk.sv
`timescale 1ns/1ps
module usb_frame_sched_chk #(
  parameter int REM_W = 14,
  parameter int LST_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic [REM_W-1:0] frame_interval,
  input logic             bit_tick,
  input logic [REM_W-1:0] frame_remaining,
  input logic             per_req,
  input logic             per_busy,
  input logic             per_grant,
  input logic             cb_busy,
  input logic             cb_grant,
  input logic             periodic_prio,
  input logic             ls_permit,
  input logic             ls_deferred,
  input logic [REM_W-1:0] ps_val,
  input logic [LST_W-1:0] lst_val
);
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> frame_remaining == $past(frame_interval));
  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && bit_tick && frame_remaining != '0) |=>
      frame_remaining == $past(frame_remaining) - 1'b1);
  assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && frame_remaining == '0) |=> frame_remaining == '0);
  assert_prio_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periodic_prio) |-> $past(frame_remaining <= ps_val));
  assert_prio_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periodic_prio) |-> $past(ps_val) != '0);
  assert_per_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_prio && per_req && !per_grant && !cb_grant) |=> per_grant);
  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_grant, cb_grant}));
  assert_cb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_grant && cb_busy) |=> (cb_grant && !per_grant));
  assert_per_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (per_grant && per_busy) |=> per_grant);
  assert_ls_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ls_permit |-> $past(frame_remaining > REM_W'(lst_val)));
  assert_defer_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ls_deferred |-> !ls_permit);
  assert_defer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !ls_deferred);
  assert_prio_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !periodic_prio);
endmodule

bind usb_frame_sched usb_frame_sched_chk #(.REM_W(REM_W), .LST_W(LST_W)) chk_i (.*);

// File: tb/usb_frame_sched_tb_top.sv
`timescale 1ns/1ps
module usb_frame_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        sof = 1'b0;
  logic [13:0] frame_interval = '0;
  logic        bit_tick = 1'b0;
  logic [13:0] frame_remaining;
  logic        per_req = 1'b0, per_busy = 1'b0, per_grant;
  logic        cb_req = 1'b0, cb_busy = 1'b0, cb_grant;
  logic        periodic_prio;
  logic        ls_req = 1'b0, ls_permit, ls_deferred;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_frame_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sof(sof),
    .frame_interval(frame_interval), .bit_tick(bit_tick),
    .frame_remaining(frame_remaining), .per_req(per_req),
    .per_busy(per_busy), .per_grant(per_grant), .cb_req(cb_req),
    .cb_busy(cb_busy), .cb_grant(cb_grant), .periodic_prio(periodic_prio),
    .ls_req(ls_req), .ls_permit(ls_permit), .ls_deferred(ls_deferred)
  );

  typedef struct packed {
    logic [13:0] ps;
    logic [11:0] lst;
    logic [13:0] fi;
    logic [7:0]  ticks;
    logic [13:0] rem;
    logic        prio;
    logic        permit;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{14'd0,     12'd20,   14'd100,   8'd90, 14'd10,    1'b0, 1'b0},
    '{14'd60,    12'd20,   14'd100,   8'd30, 14'd70,    1'b0, 1'b1},
    '{14'd60,    12'd20,   14'd100,   8'd40, 14'd60,    1'b1, 1'b1},
    '{14'd60,    12'd20,   14'd100,   8'd80, 14'd20,    1'b1, 1'b0},
    '{14'd60,    12'd20,   14'd100,   8'd79, 14'd21,    1'b1, 1'b1},
    '{14'd16383, 12'd0,    14'd30,    8'd40, 14'd0,     1'b1, 1'b0},
    '{14'd5,     12'd4095, 14'd16383, 8'd10, 14'd16373, 1'b0, 1'b1}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic a, input logic [15:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic new_frame(input logic [13:0] fi);
    sof = 1'b1; frame_interval = fi;
    step();
    sof = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    bit_tick = 1'b1;
    repeat (n) step();
    bit_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // Reset state
    cfg_addr = 1'b0; #1;
    check("R1 reset pstart", cfg_rdata, 32'h0);
    cfg_addr = 1'b1; #1;
    check("R2 reset lsthr", cfg_rdata, 32'h628);
    check("R3 reset remaining", frame_remaining, 32'h0);
    check("R7 reset grants", {per_grant, cb_grant}, 32'h0);
    check("R8 reset permit", {ls_permit, ls_deferred}, 32'h0);

    // Field width masking
    cfg_write(1'b0, 16'hFFFF);
    cfg_addr = 1'b0; #1;
    check("R1 pstart mask", cfg_rdata, 32'h3FFF);
    cfg_write(1'b1, 16'hFFFF);
    cfg_addr = 1'b1; #1;
    check("R2 lsthr mask", cfg_rdata, 32'h0FFF);

    // Vector table: counter, priority switch and low-speed gate
    for (int i = 0; i < NVEC; i++) begin
      cfg_write(1'b0, {2'b0, VECS[i].ps});
      cfg_write(1'b1, {4'b0, VECS[i].lst});
      new_frame(VECS[i].fi);
      check("R3 reload", frame_remaining, {18'b0, VECS[i].fi});
      run_ticks(VECS[i].ticks);
      step();
      check("R3 remaining", frame_remaining, {18'b0, VECS[i].rem});
      check("R4 R5 prio", periodic_prio, {31'b0, VECS[i].prio});
      ls_req = 1'b1;
      step();
      ls_req = 1'b0;
      check("R8 permit", ls_permit, {31'b0, VECS[i].permit});
      check("R9 deferred", ls_deferred, {31'b0, ~VECS[i].permit});
    end

    // In-flight control/bulk is not cut off by periodic priority
    cfg_write(1'b0, 16'd50);
    cfg_write(1'b1, 16'd20);
    new_frame(14'd100);
    check("R9 sof clears deferred", ls_deferred, 32'h0);
    per_req = 1'b1; cb_req = 1'b1;
    step();
    check("R6 cb wins early", {per_grant, cb_grant}, 32'h1);
    cb_busy = 1'b1;
    run_ticks(60);
    step();
    check("R4 prio set", periodic_prio, 32'h1);
    check("R7 cb held busy", {per_grant, cb_grant}, 32'h1);
    cb_busy = 1'b0;
    step();
    check("R7 release", {per_grant, cb_grant}, 32'h0);
    step();
    check("R6 per wins late", {per_grant, cb_grant}, 32'h2);
    per_busy = 1'b1;
    step();
    check("R7 per held busy", {per_grant, cb_grant}, 32'h2);
    per_busy = 1'b0; per_req = 1'b0;
    step();
    step();
    check("R6 cb when no periodic work", {per_grant, cb_grant}, 32'h1);
    cb_req = 1'b0;
    step();
    step();

    // Start of frame restores control/bulk priority
    new_frame(14'd100);
    check("R10 prio cleared", periodic_prio, 32'h0);
    per_req = 1'b1; cb_req = 1'b1;
    step();
    check("R10 cb wins after sof", {per_grant, cb_grant}, 32'h1);
    per_req = 1'b0; cb_req = 1'b0;
    step();
    step();

    // Zero periodic-start disables the switch; counter saturates
    cfg_write(1'b0, 16'd0);
    new_frame(14'd100);
    run_ticks(120);
    step();
    check("R3 saturate", frame_remaining, 32'h0);
    check("R5 no prio", periodic_prio, 32'h0);
    per_req = 1'b1; cb_req = 1'b1;
    step();
    check("R5 cb keeps priority", {per_grant, cb_grant}, 32'h1);
    per_req = 1'b0; cb_req = 1'b0;
    step();
    step();

    // Deferred low-speed request retried after next sof
    cfg_write(1'b1, 16'd50);
    new_frame(14'd100);
    run_ticks(60);
    ls_req = 1'b1;
    step();
    check("R9 refused", {ls_permit, ls_deferred}, 32'h1);
    step();
    check("R9 stays deferred", {ls_permit, ls_deferred}, 32'h1);
    new_frame(14'd100);
    check("R9 cleared at sof", {ls_permit, ls_deferred}, 32'h0);
    step();
    check("R9 retry permitted", {ls_permit, ls_deferred}, 32'h2);
    ls_req = 1'b0;
    step();
    check("R8 permit drops", ls_permit, 32'h0);

    finish_run();
  end
endmodule